// File: doc/BRIEF.md
# Halfword and Signed-Byte Transfer Execution Unit

This unit carries out the halfword and sign-extending transfer instructions of a 32-bit load/store processor. Each cycle it may accept one instruction word together with the current contents of three registers: the base, the offset register and the store-data register. The register file supplies these values. From the instruction fields the unit works out an effective address, issues one memory access of byte or halfword size and, for loads, widens the returned data to the full register width.

A condition-pass input gates the instruction. A failed condition, or a word that is not a halfword/signed transfer, causes no memory access and no register write. One cycle after acceptance the unit raises its memory request, and the memory answers combinationally in that same cycle. One further cycle later the unit presents up to two register write ports: one for the destination register and one for the updated base. Alignment checking and the register file are the surrounding pipeline's job.

Top module: `hx_xfer_unit`

## Requirements
- R1: An instruction is accepted only if bits 27:25 are 000, bit 7 and bit 4 are 1, and bits 6:5 are not 00. Bits 6:5 = 01 is an unsigned halfword load or store; 10 (signed byte) and 11 (signed halfword) are legal only with bit 20 (load) = 1. Any other word causes no request and no register write.
- R2: With bit 22 = 1 the offset is the 8-bit value {bits 11:8, bits 3:0}, zero-extended. With bit 22 = 0 the offset is the offset-register input.
- R3: With bit 24 = 1 the access address is base ± offset. With bit 24 = 0 the access address is the unmodified base.
- R4: Bit 23 = 1 adds the offset and bit 23 = 0 subtracts it, modulo 2^32.
- R5: The base register (index bits 19:16) is written with base ± offset when bit 24 = 0 or bit 21 = 1. Otherwise it is not written.
- R6: A signed load copies bit 15 of the returned halfword, or bit 7 of the returned byte, into all upper bits of the result. The access size output is 1 for halfword and 0 for byte.
- R7: An unsigned halfword load writes the low 16 returned bits, zero-extended, to the register at index bits 15:12.
- R8: A store (bit 20 = 0) raises the write strobe with halfword size. The write data carries the low 16 bits of the store-data input with all upper bits zero, and no destination register is written.
- R9: When the condition-pass input is low, an accepted word produces no memory request and no register write.
- R10: On a load with base writeback where the destination index equals the base index, only the loaded value is written, and the base write port stays idle.
- R11: After reset all request and write-enable outputs are low. The request appears one cycle after the instruction is presented, and the register writes appear one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction presented this cycle |
| cond_pass_i | input | 1 | Condition code check passed |
| instr_i | input | 32 | Instruction word |
| base_i | input | DW | Base register value |
| offs_i | input | DW | Offset register value |
| sdata_i | input | DW | Store-data register value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_size_o | output | 1 | 1 = halfword, 0 = byte |
| mem_addr_o | output | DW | Access address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid in the request cycle |
| dst_we_o | output | 1 | Destination register write enable |
| dst_idx_o | output | 4 | Destination register index |
| dst_data_o | output | DW | Destination register value |
| bas_we_o | output | 1 | Base register write enable |
| bas_idx_o | output | 4 | Base register index |
| bas_data_o | output | DW | Updated base value |

## Verification
The bench builds the unit with its defaults: a 32-bit data path and registered write ports (OUT_REG = 1). That fixes the two-cycle latency, so request fields and write-back fields can be checked in separate, known cycles. With a 32-bit path, subtraction wrap-around and the full upper-bit fill of sign extension become visible. The combinational write-back variant is not exercised by this bench.

// File: rtl/hx_pkg.sv
package hx_pkg;
   typedef struct packed {
      logic       legal;
      logic       pre;
      logic       up;
      logic       imm;
      logic       wback;
      logic       load;
      logic       sgn;
      logic       half;
      logic [3:0] rn;
      logic [3:0] rd;
      logic [7:0] imm8;
   } hx_dec_t;

   localparam logic SZ_BYTE = 1'b0;
   localparam logic SZ_HALF = 1'b1;
endpackage

// File: rtl/hx_decode.sv
module hx_decode
   import hx_pkg::*;
(
   input  logic [31:0] instr,
   output hx_dec_t     dec
);
   logic fmt_ok;
   logic kind_ok;

   always_comb begin
      // class bits and the two fixed ones around the sub-opcode
      fmt_ok  = (instr[27:25] == 3'b000) && instr[7] && instr[4];
      // 00 is not a transfer; signed kinds exist only as loads
      kind_ok = (instr[6:5] != 2'b00) && !(instr[6] && !instr[20]);
      dec.legal = fmt_ok && kind_ok;
      dec.pre   = instr[24];
      dec.up    = instr[23];
      dec.imm   = instr[22];
      dec.wback = instr[21];
      dec.load  = instr[20];
      dec.rn    = instr[19:16];
      dec.rd    = instr[15:12];
      dec.sgn   = instr[6];
      dec.half  = instr[5];
      dec.imm8  = {instr[11:8], instr[3:0]};
   end
endmodule

// File: rtl/hx_agen.sv
module hx_agen #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] base,
   input  logic [DW-1:0] roff,
   input  logic [7:0]    imm8,
   input  logic          use_imm,
   input  logic          up,
   input  logic          pre,
   output logic [DW-1:0] acc_addr,
   output logic [DW-1:0] new_base
);
   localparam int PADW = DW - 8;

   logic [DW-1:0] off;

   always_comb begin
      off      = use_imm ? {{PADW{1'b0}}, imm8} : roff;
      new_base = up ? base + off : base - off;
      acc_addr = pre ? new_base : base;
   end
endmodule

// File: rtl/hx_extend.sv
module hx_extend #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] raw,
   input  logic          sgn,
   input  logic          half,
   output logic [DW-1:0] ext
);
   localparam int HUP = DW - 16;
   localparam int BUP = DW - 8;

   logic hfill;
   logic bfill;

   always_comb begin
      hfill = sgn & raw[15];
      bfill = sgn & raw[7];
      if (half) ext = {{HUP{hfill}}, raw[15:0]};
      else      ext = {{BUP{bfill}}, raw[7:0]};
   end
endmodule

// File: rtl/hx_xfer_unit.sv
module hx_xfer_unit
   import hx_pkg::*;
#(
   parameter int DW      = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_i,
   input  logic          cond_pass_i,
   input  logic [31:0]   instr_i,
   input  logic [DW-1:0] base_i,
   input  logic [DW-1:0] offs_i,
   input  logic [DW-1:0] sdata_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic          mem_size_o,
   output logic [DW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   output logic          dst_we_o,
   output logic [3:0]    dst_idx_o,
   output logic [DW-1:0] dst_data_o,
   output logic          bas_we_o,
   output logic [3:0]    bas_idx_o,
   output logic [DW-1:0] bas_data_o
);
   localparam int WUP = DW - 16;

   if (DW < 16) begin : g_bad_width
      $error("hx_xfer_unit: DW must be at least 16");
   end

   hx_dec_t       dec;
   logic [DW-1:0] acc_addr;
   logic [DW-1:0] new_base;
   logic          fire;

   hx_decode u_dec (.instr(instr_i), .dec(dec));

   hx_agen #(.DW(DW)) u_agen (
      .base(base_i), .roff(offs_i), .imm8(dec.imm8), .use_imm(dec.imm),
      .up(dec.up), .pre(dec.pre), .acc_addr(acc_addr), .new_base(new_base)
   );

   assign fire = valid_i && cond_pass_i && dec.legal;

   // access stage
   logic          req_q, we_q, size_q, sgn_q, wbb_q;
   logic [DW-1:0] addr_q, wdata_q, nb_q;
   logic [3:0]    rd_q, rn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         we_q    <= 1'b0;
         size_q  <= SZ_BYTE;
         sgn_q   <= 1'b0;
         wbb_q   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         nb_q    <= '0;
         rd_q    <= '0;
         rn_q    <= '0;
      end else begin
         req_q <= fire;
         if (fire) begin
            we_q    <= !dec.load;
            size_q  <= dec.half ? SZ_HALF : SZ_BYTE;
            sgn_q   <= dec.sgn;
            wbb_q   <= !dec.pre || dec.wback;
            addr_q  <= acc_addr;
            wdata_q <= {{WUP{1'b0}}, sdata_i[15:0]};
            nb_q    <= new_base;
            rd_q    <= dec.rd;
            rn_q    <= dec.rn;
         end
      end
   end

   assign mem_req_o   = req_q;
   assign mem_we_o    = req_q && we_q;
   assign mem_size_o  = size_q;
   assign mem_addr_o  = addr_q;
   assign mem_wdata_o = wdata_q;

   // write-back stage
   logic [DW-1:0] ext;
   logic          dwe_n, bwe_n;

   hx_extend #(.DW(DW)) u_ext (
      .raw(mem_rdata_i), .sgn(sgn_q), .half(size_q), .ext(ext)
   );

   always_comb begin
      dwe_n = req_q && !we_q;
      // loaded data wins a clash of destination and base
      bwe_n = req_q && wbb_q && !(dwe_n && (rd_q == rn_q));
   end

   if (OUT_REG) begin : g_wb_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dst_we_o   <= 1'b0;
            dst_idx_o  <= '0;
            dst_data_o <= '0;
            bas_we_o   <= 1'b0;
            bas_idx_o  <= '0;
            bas_data_o <= '0;
         end else begin
            dst_we_o   <= dwe_n;
            dst_idx_o  <= rd_q;
            dst_data_o <= ext;
            bas_we_o   <= bwe_n;
            bas_idx_o  <= rn_q;
            bas_data_o <= nb_q;
         end
      end
   end else begin : g_wb_comb
      always_comb begin
         dst_we_o   = dwe_n;
         dst_idx_o  = rd_q;
         dst_data_o = ext;
         bas_we_o   = bwe_n;
         bas_idx_o  = rn_q;
         bas_data_o = nb_q;
      end
   end

   // assertions
   p_req_after_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> $past(valid_i && cond_pass_i));

   p_fail_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !cond_pass_i) |=> !mem_req_o);

   p_store_is_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (mem_size_o == SZ_HALF));

   p_single_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_we_o && bas_we_o) |-> (dst_idx_o != bas_idx_o));

   if (OUT_REG) begin : g_lat_chk
      p_wb_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
         dst_we_o |-> $past(mem_req_o && !mem_we_o));
   end
endmodule

// File: tb/hx_xfer_unit_tb.sv
module hx_xfer_unit_tb;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid_i = 1'b0;
   logic          cond_pass_i = 1'b0;
   logic [31:0]   instr_i = '0;
   logic [DW-1:0] base_i = '0, offs_i = '0, sdata_i = '0, mem_rdata_i = '0;
   logic          mem_req_o, mem_we_o, mem_size_o;
   logic [DW-1:0] mem_addr_o, mem_wdata_o;
   logic          dst_we_o, bas_we_o;
   logic [3:0]    dst_idx_o, bas_idx_o;
   logic [DW-1:0] dst_data_o, bas_data_o;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   hx_xfer_unit #(.DW(DW), .OUT_REG(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cond_pass_i(cond_pass_i),
      .instr_i(instr_i), .base_i(base_i), .offs_i(offs_i), .sdata_i(sdata_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_size_o(mem_size_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .dst_we_o(dst_we_o), .dst_idx_o(dst_idx_o), .dst_data_o(dst_data_o),
      .bas_we_o(bas_we_o), .bas_idx_o(bas_idx_o), .bas_data_o(bas_data_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] enc(input bit p, input bit u, input bit i,
         input bit w, input bit l, input logic [3:0] rn, input logic [3:0] rd,
         input logic [1:0] sh, input logic [7:0] im);
      return {4'hE, 3'b000, p, u, i, w, l, rn, rd, im[7:4], 1'b1, sh, 1'b1, im[3:0]};
   endfunction

   // present one instruction; leaves time just after the request cycle's negedge
   task automatic issue(input logic [31:0] ins, input bit pass);
      @(negedge clk);
      instr_i = ins; cond_pass_i = pass; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   task automatic to_wb();
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!mem_req_o, "R11 reset req", {31'b0, mem_req_o}, 0);
      chk(!dst_we_o && !bas_we_o, "R11 reset we", {30'b0, dst_we_o, bas_we_o}, 0);
   endtask

   task automatic t_store_pre_imm();
      base_i = 32'h0000_1000; sdata_i = 32'hDEAD_BEEF;
      issue(enc(1, 1, 1, 0, 0, 4'd3, 4'd5, 2'b01, 8'h24), 1'b1);
      chk(mem_req_o && mem_we_o, "R8 store strobe", {30'b0, mem_req_o, mem_we_o}, 3);
      chk(mem_size_o == 1'b1, "R8 store size", {31'b0, mem_size_o}, 1);
      chk(mem_addr_o == 32'h1024, "R2 R3 R4 pre imm addr", mem_addr_o, 32'h1024);
      chk(mem_wdata_o == 32'h0000_BEEF, "R8 store data", mem_wdata_o, 32'h0000_BEEF);
      to_wb();
      chk(!dst_we_o, "R8 no dst write", {31'b0, dst_we_o}, 0);
      chk(!bas_we_o, "R5 no base write", {31'b0, bas_we_o}, 0);
   endtask

   task automatic t_load_post_reg();
      base_i = 32'h0000_2000; offs_i = 32'h10; mem_rdata_i = 32'h1234_F00D;
      issue(enc(0, 0, 0, 0, 1, 4'd2, 4'd7, 2'b01, 8'h00), 1'b1);
      chk(mem_req_o && !mem_we_o, "R3 load req", {30'b0, mem_req_o, mem_we_o}, 2);
      chk(mem_addr_o == 32'h2000, "R3 post addr", mem_addr_o, 32'h2000);
      to_wb();
      chk(dst_we_o && dst_idx_o == 4'd7, "R7 dst idx", {28'b0, dst_idx_o}, 7);
      chk(dst_data_o == 32'h0000_F00D, "R7 zero ext", dst_data_o, 32'h0000_F00D);
      chk(bas_we_o && bas_idx_o == 4'd2, "R5 base we", {28'b0, bas_idx_o}, 2);
      chk(bas_data_o == 32'h1FF0, "R4 R5 post sub", bas_data_o, 32'h1FF0);
   endtask

   task automatic t_signed_byte();
      base_i = 32'h100; mem_rdata_i = 32'h0000_5580;
      issue(enc(1, 1, 1, 1, 1, 4'd1, 4'd6, 2'b10, 8'h0F), 1'b1);
      chk(mem_size_o == 1'b0, "R6 byte size", {31'b0, mem_size_o}, 0);
      chk(mem_addr_o == 32'h10F, "R3 pre addr", mem_addr_o, 32'h10F);
      to_wb();
      chk(dst_data_o == 32'hFFFF_FF80, "R6 byte sext", dst_data_o, 32'hFFFF_FF80);
      chk(bas_we_o && bas_data_o == 32'h10F, "R5 pre wb", bas_data_o, 32'h10F);
      mem_rdata_i = 32'hFFFF_FF7F;
      issue(enc(1, 1, 1, 0, 1, 4'd1, 4'd6, 2'b10, 8'h01), 1'b1);
      to_wb();
      chk(dst_data_o == 32'h0000_007F, "R6 byte positive", dst_data_o, 32'h7F);
   endtask

   task automatic t_signed_half();
      base_i = 32'h50; offs_i = 32'h4; mem_rdata_i = 32'hABCD_8001;
      issue(enc(1, 0, 0, 0, 1, 4'd8, 4'd9, 2'b11, 8'h00), 1'b1);
      chk(mem_addr_o == 32'h4C, "R4 pre sub", mem_addr_o, 32'h4C);
      chk(mem_size_o == 1'b1, "R6 half size", {31'b0, mem_size_o}, 1);
      to_wb();
      chk(dst_data_o == 32'hFFFF_8001, "R6 half sext", dst_data_o, 32'hFFFF_8001);
      chk(!bas_we_o, "R5 no wb", {31'b0, bas_we_o}, 0);
   endtask

   task automatic t_wrap();
      base_i = 32'h2; offs_i = 32'h6;
      issue(enc(1, 0, 0, 0, 0, 4'd0, 4'd1, 2'b01, 8'h00), 1'b1);
      chk(mem_addr_o == 32'hFFFF_FFFC, "R4 wrap", mem_addr_o, 32'hFFFF_FFFC);
      to_wb();
   endtask

   task automatic t_cond_fail();
      issue(enc(1, 1, 1, 1, 1, 4'd1, 4'd2, 2'b01, 8'h10), 1'b0);
      chk(!mem_req_o, "R9 no req", {31'b0, mem_req_o}, 0);
      to_wb();
      chk(!dst_we_o && !bas_we_o, "R9 no write", {30'b0, dst_we_o, bas_we_o}, 0);
   endtask

   task automatic t_illegal();
      issue(enc(0, 1, 1, 1, 0, 4'd1, 4'd2, 2'b10, 8'h10), 1'b1);
      chk(!mem_req_o, "R1 signed store ignored", {31'b0, mem_req_o}, 0);
      to_wb();
      chk(!dst_we_o && !bas_we_o, "R1 no write", {30'b0, dst_we_o, bas_we_o}, 0);
      issue(enc(0, 1, 1, 1, 1, 4'd1, 4'd2, 2'b01, 8'h10) | 32'h0200_0000, 1'b1);
      chk(!mem_req_o, "R1 class bits", {31'b0, mem_req_o}, 0);
      issue(enc(0, 1, 1, 1, 1, 4'd1, 4'd2, 2'b00, 8'h10), 1'b1);
      chk(!mem_req_o, "R1 kind 00", {31'b0, mem_req_o}, 0);
      to_wb();
   endtask

   task automatic t_same_reg();
      base_i = 32'h400; mem_rdata_i = 32'h0000_1357;
      issue(enc(0, 1, 1, 0, 1, 4'd4, 4'd4, 2'b01, 8'h02), 1'b1);
      to_wb();
      chk(dst_we_o && dst_data_o == 32'h1357, "R10 load wins", dst_data_o, 32'h1357);
      chk(!bas_we_o, "R10 base idle", {31'b0, bas_we_o}, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_store_pre_imm();
            t_load_post_reg();
            t_signed_byte();
            t_signed_half();
            t_wrap();
            t_cond_fail();
            t_illegal();
            t_same_reg();
         end
         begin
            repeat (5000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule